// File: doc/BRIEF.md
# Leveled Priority Interrupt Controller

This block gathers one-cycle underflow pulses from three timer channels and turns them into a single prioritized interrupt request for a processor core. Every channel keeps a sticky pending flag, an enable bit and a 3-bit priority level. These live in four small registers that software writes over a plain write-strobe register bus. The same bus gives a combinational read-back.

Each cycle, an arbiter looks at the channels that are both pending and enabled. The highest level wins, and among equal levels the lower channel index wins. The winner is then gated by the core's global interrupt enable, its current mask level and a blocking non-maskable-pending input. The accepted request is registered together with its vector number, vector address and level. That registered request is held steady until the core acknowledges it or the held channel stops qualifying. An acknowledge clears the flag of the presented channel.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: A pulse on `tmr_uflow[c]` sets channel c's flag on that clock edge whether its enable is 0 or 1. Flags of channels 0, 1 and 2 read back at bits 9, 10 and 11 of register address 0.
- R2: Writing 1 to a flag bit at address 0 clears that flag, and writing 0 leaves it unchanged. If an underflow pulse for the channel arrives in the same cycle as the clear, the flag stays set.
- R3: A channel can produce a request only when both its flag and its enable are 1. Enables sit at bits 9, 10 and 11 of register address 1.
- R4: Each channel has a 3-bit level. Channel 0 uses bits 10:8 of address 2, channel 1 uses bits 2:0 of address 3, and channel 2 uses bits 10:8 of address 3. Among qualifying channels the highest level wins, whatever the channel index.
- R5: When qualifying channels share the top level, channel 0 beats channel 1 and channel 1 beats channel 2.
- R6: `irq_req` is raised only if, on the cycle before, `core_ie` was 1, `nmi_pend` was 0 and the winning level was strictly greater than `core_il`.
- R7: While `irq_req` is 1, `irq_vec_num` is 13 + channel and `irq_vec_addr` is 0x8000 + 4 × `irq_vec_num`. `irq_level` is the presented channel's level.
- R8: The outputs are registered. Once a channel is presented, a newly pending channel of a higher level does not replace it while the presented channel still qualifies.
- R9: `irq_ack` while `irq_req` is 1 clears the presented channel's flag and drops `irq_req` on the next cycle. The next winner then appears one cycle later.
- R10: After reset all flags, enables and levels read 0, and `irq_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_uflow | input | 3 | Per-channel underflow pulses |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Combinational read data for `reg_addr` |
| core_ie | input | 1 | Core global interrupt enable |
| core_il | input | 3 | Core current interrupt mask level |
| nmi_pend | input | 1 | Higher-precedence source pending; blocks requests |
| irq_ack | input | 1 | Acknowledge of the presented request |
| irq_req | output | 1 | Registered interrupt request |
| irq_vec_num | output | 8 | Vector number of the presented channel |
| irq_vec_addr | output | 16 | Vector address of the presented channel |
| irq_level | output | 3 | Level of the presented channel |

## Verification
The bench uses the package defaults: three channels, 3-bit levels and 16-bit registers. With these values every level from 0 to 7 is reachable, and three-way ties can be built at any level. Random rounds draw enables, levels, pulse masks, mask level, global enable and the blocking input. Directed sequences cover the clear-versus-pulse collision, strict mask comparison, hold against a higher-level newcomer, and acknowledge followed by the next winner.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;

    localparam int NCH        = 3;
    localparam int LVL_W      = 3;
    localparam int CH_W       = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int CH_SPAN    = 1 << CH_W;
    localparam int DATA_W     = 16;
    localparam int ADDR_W     = 3;
    localparam int FLAG_LSB   = 9;
    localparam int LVL_HI_OFS = 8;
    localparam int NLVL_REG   = (NCH + 2) / 2;
    localparam int VEC_W      = 8;
    localparam int VADDR_W    = 16;
    localparam int VEC_FIRST  = 13;

    localparam logic [ADDR_W-1:0]  A_FLAG     = ADDR_W'(0);
    localparam logic [ADDR_W-1:0]  A_EN       = ADDR_W'(1);
    localparam logic [ADDR_W-1:0]  A_LVL0     = ADDR_W'(2);
    localparam logic [VADDR_W-1:0] VADDR_BASE = VADDR_W'(16'h8000);

    typedef logic [LVL_W-1:0] lvl_t;

    typedef struct packed {
        logic            valid;
        logic [CH_W-1:0] ch;
        lvl_t            lvl;
    } pick_t;

    // level register index holding channel c (channel 0 in upper half of first)
    function automatic int lvl_reg(input int c);
        return (c + 1) / 2;
    endfunction

    function automatic int lvl_pos(input int c);
        return ((c + 1) % 2) * LVL_HI_OFS;
    endfunction

    function automatic logic [VEC_W-1:0] vec_num(input logic [CH_W-1:0] ch);
        return VEC_W'(VEC_FIRST) + VEC_W'(ch);
    endfunction

    function automatic logic [VADDR_W-1:0] vec_addr(input logic [VEC_W-1:0] n);
        return VADDR_BASE + (VADDR_W'(n) << 2);
    endfunction

endpackage

// File: rtl/lvl_irq_regs.sv
module lvl_irq_regs
    import lvl_irq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NCH-1:0]        uflow,
    input  logic                  wr,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [NCH-1:0]        ack_clr,
    output logic [DATA_W-1:0]     rdata,
    output logic [NCH-1:0]        flags,
    output logic [NCH-1:0]        enables,
    output logic [NCH-1:0][LVL_W-1:0] lvls
);

    logic [NCH-1:0] clr;

    always_comb begin
        clr = ack_clr;
        if (wr && addr == A_FLAG)
            clr = clr | wdata[FLAG_LSB +: NCH];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags   <= '0;
            enables <= '0;
            lvls    <= '0;
        end else begin
            // a pulse outranks a clear landing in the same cycle
            flags <= (flags & ~clr) | uflow;
            if (wr && addr == A_EN)
                enables <= wdata[FLAG_LSB +: NCH];
            for (int c = 0; c < NCH; c++) begin
                if (wr && addr == A_LVL0 + ADDR_W'(lvl_reg(c)))
                    lvls[c] <= wdata[lvl_pos(c) +: LVL_W];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == A_FLAG) begin
            rdata[FLAG_LSB +: NCH] = flags;
        end else if (addr == A_EN) begin
            rdata[FLAG_LSB +: NCH] = enables;
        end else begin
            for (int c = 0; c < NCH; c++) begin
                if (addr == A_LVL0 + ADDR_W'(lvl_reg(c)))
                    rdata[lvl_pos(c) +: LVL_W] = lvls[c];
            end
        end
    end

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_flag_chk
            AST_FLAG_SET_ON_PULSE: assert property (@(posedge clk) disable iff (rst)
                uflow[g] |=> flags[g]); // R1
            AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (rst)
                (clr[g] && !uflow[g]) |=> !flags[g]); // R2
        end
    endgenerate

endmodule

// File: rtl/lvl_irq_pick.sv
module lvl_irq_pick
    import lvl_irq_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NCH-1:0]            elig,
    input  logic [NCH-1:0][LVL_W-1:0] lvls,
    output pick_t                     pick
);

    logic [CH_SPAN-1:0] elig_x;

    assign elig_x = CH_SPAN'(elig);

    // scan from the top index down; >= lets a lower index take a tie
    always_comb begin
        pick = '0;
        for (int c = NCH - 1; c >= 0; c--) begin
            if (elig[c] && (!pick.valid || lvls[c] >= pick.lvl)) begin
                pick.valid = 1'b1;
                pick.ch    = CH_W'(c);
                pick.lvl   = lvls[c];
            end
        end
    end

    AST_PICK_QUALIFIES: assert property (@(posedge clk) disable iff (rst)
        pick.valid |-> elig_x[pick.ch]); // R3

    AST_PICK_PRESENT: assert property (@(posedge clk) disable iff (rst)
        (elig != '0) |-> pick.valid); // R4

endmodule

// File: rtl/lvl_irq_present.sv
module lvl_irq_present
    import lvl_irq_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  pick_t          pick,
    input  logic [NCH-1:0] elig,
    input  logic           core_ie,
    input  lvl_t           core_il,
    input  logic           nmi_pend,
    input  logic           irq_ack,
    output pick_t          cur,
    output logic [NCH-1:0] ack_clr
);

    logic [CH_SPAN-1:0] elig_x;
    logic               keep;
    logic               take;

    assign elig_x = CH_SPAN'(elig);
    assign keep   = cur.valid && elig_x[cur.ch] && core_ie && !nmi_pend && (cur.lvl > core_il);
    assign take   = pick.valid && core_ie && !nmi_pend && (pick.lvl > core_il);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else if (irq_ack && cur.valid) begin
            cur.valid <= 1'b0;
        end else if (!keep) begin
            cur       <= pick;
            cur.valid <= take;
        end
    end

    always_comb begin
        for (int c = 0; c < NCH; c++)
            ack_clr[c] = irq_ack && cur.valid && (cur.ch == CH_W'(c));
    end

    AST_REQ_GATED: assert property (@(posedge clk) disable iff (rst)
        cur.valid |-> ($past(core_ie) && !$past(nmi_pend) && (cur.lvl > $past(core_il)))); // R6

    AST_ACK_DROPS: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && cur.valid) |=> !cur.valid); // R9

    AST_HELD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (cur.valid && !irq_ack && elig_x[cur.ch] && core_ie && !nmi_pend && cur.lvl > core_il)
        |=> (cur.valid && $stable(cur.ch) && $stable(cur.lvl))); // R8

endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
    import lvl_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NCH-1:0]      tmr_uflow,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic                core_ie,
    input  logic [LVL_W-1:0]    core_il,
    input  logic                nmi_pend,
    input  logic                irq_ack,
    output logic                irq_req,
    output logic [VEC_W-1:0]    irq_vec_num,
    output logic [VADDR_W-1:0]  irq_vec_addr,
    output logic [LVL_W-1:0]    irq_level
);

    logic [NCH-1:0]            flags;
    logic [NCH-1:0]            enables;
    logic [NCH-1:0][LVL_W-1:0] lvls;
    logic [NCH-1:0]            ack_clr;
    logic [NCH-1:0]            elig;
    pick_t                     pick;
    pick_t                     cur;

    lvl_irq_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .uflow   (tmr_uflow),
        .wr      (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .ack_clr (ack_clr),
        .rdata   (reg_rdata),
        .flags   (flags),
        .enables (enables),
        .lvls    (lvls)
    );

    assign elig = flags & enables;

    lvl_irq_pick u_pick (
        .clk  (clk),
        .rst  (rst),
        .elig (elig),
        .lvls (lvls),
        .pick (pick)
    );

    lvl_irq_present u_present (
        .clk      (clk),
        .rst      (rst),
        .pick     (pick),
        .elig     (elig),
        .core_ie  (core_ie),
        .core_il  (core_il),
        .nmi_pend (nmi_pend),
        .irq_ack  (irq_ack),
        .cur      (cur),
        .ack_clr  (ack_clr)
    );

    assign irq_req      = cur.valid;
    assign irq_vec_num  = vec_num(cur.ch);
    assign irq_vec_addr = vec_addr(irq_vec_num);
    assign irq_level    = cur.lvl;

    AST_ACK_CLEARS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && irq_req && !tmr_uflow[0] && irq_vec_num == VEC_W'(VEC_FIRST))
        |=> !flags[0]); // R9

endmodule

// File: tb/lvl_irq_ctrl_tb.sv
module lvl_irq_ctrl_tb;
    import lvl_irq_pkg::*;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [NCH-1:0]      tmr_uflow = '0;
    logic                reg_wr = 1'b0;
    logic [ADDR_W-1:0]   reg_addr = '0;
    logic [DATA_W-1:0]   reg_wdata = '0;
    logic [DATA_W-1:0]   reg_rdata;
    logic                core_ie = 1'b0;
    logic [LVL_W-1:0]    core_il = '0;
    logic                nmi_pend = 1'b0;
    logic                irq_ack = 1'b0;
    logic                irq_req;
    logic [VEC_W-1:0]    irq_vec_num;
    logic [VADDR_W-1:0]  irq_vec_addr;
    logic [LVL_W-1:0]    irq_level;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    logic [2:0] m_en;
    logic [2:0] m_flag;
    logic [2:0] m_lvl [3];

    always #2 clk = ~clk;

    lvl_irq_ctrl u_dut (
        .clk          (clk),
        .rst          (rst),
        .tmr_uflow    (tmr_uflow),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .core_ie      (core_ie),
        .core_il      (core_il),
        .nmi_pend     (nmi_pend),
        .irq_ack      (irq_ack),
        .irq_req      (irq_req),
        .irq_vec_num  (irq_vec_num),
        .irq_vec_addr (irq_vec_addr),
        .irq_level    (irq_level)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [2:0] m);
        @(negedge clk);
        tmr_uflow = m;
        @(negedge clk);
        tmr_uflow = '0;
    endtask

    task automatic put_levels();
        wr(3'd2, {5'd0, m_lvl[0], 8'd0});
        wr(3'd3, {5'd0, m_lvl[2], 5'd0, m_lvl[1]});
    endtask

    // expected winner: highest level, lowest index on a tie
    task automatic expect_out(input string tag);
        int  w = -1;
        bit  req;
        for (int c = 0; c < 3; c++) begin
            if (m_flag[c] && m_en[c] && (w < 0 || m_lvl[c] > m_lvl[w]))
                w = c;
        end
        req = (w >= 0) && core_ie && !nmi_pend && (m_lvl[w] > core_il);
        chk(irq_req == req, {tag, " req"}, irq_req, req);
        if (req && irq_req) begin
            chk(irq_vec_num == 8'(13 + w), {tag, " R7 vec_num"}, irq_vec_num, 13 + w);
            chk(irq_vec_addr == 16'(32'h8000 + 4 * (13 + w)), {tag, " R7 vec_addr"},
                irq_vec_addr, 32'h8000 + 4 * (13 + w));
            chk(irq_level == m_lvl[w], {tag, " level"}, irq_level, m_lvl[w]);
        end
    endtask

    task automatic quiesce();
        core_ie = 1'b0; nmi_pend = 1'b0;
        waitn(2);
        wr(3'd0, 16'h0E00);
        m_flag = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        void'($urandom(32'd4242));
        m_en = '0; m_flag = '0;
        for (int c = 0; c < 3; c++) m_lvl[c] = '0;

        waitn(3);
        rst = 1'b0;
        waitn(1);
        // R10 reset state
        chk(irq_req == 1'b0, "R10 req after reset", irq_req, 0);
        for (int a = 0; a < 4; a++) begin
            rd(3'(a), d);
            chk(d == 16'h0, "R10 register after reset", d, 0);
        end

        // R1 flag sets with enable 0; R3 no request without enable
        core_ie = 1'b1; core_il = 3'd0;
        m_lvl[1] = 3'd6; put_levels();
        pulse(3'b010);
        waitn(2);
        rd(3'd0, d);
        chk(d == 16'h0400, "R1 flag set while disabled", d, 16'h0400);
        chk(irq_req == 1'b0, "R3 no request while disabled", irq_req, 0);

        // R2 clear colliding with pulse: pulse wins
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 16'h0400; tmr_uflow = 3'b010;
        @(negedge clk);
        reg_wr = 1'b0; tmr_uflow = '0;
        rd(3'd0, d);
        chk(d == 16'h0400, "R2 pulse beats clear", d, 16'h0400);
        wr(3'd0, 16'h0400);
        rd(3'd0, d);
        chk(d == 16'h0000, "R2 write-one clears", d, 0);

        // R5 tie between three channels at level 4
        quiesce();
        m_en = 3'b111; wr(3'd1, 16'h0E00);
        m_lvl[0] = 3'd4; m_lvl[1] = 3'd4; m_lvl[2] = 3'd4; put_levels();
        pulse(3'b111); m_flag = 3'b111;
        core_ie = 1'b1; core_il = 3'd2;
        waitn(3);
        expect_out("R5 three-way tie");
        chk(irq_vec_num == 8'd13, "R5 channel 0 wins tie", irq_vec_num, 13);

        // R6 strict comparison and blocking input
        quiesce();
        m_lvl[0] = 3'd0; m_lvl[1] = 3'd0; m_lvl[2] = 3'd3; put_levels();
        pulse(3'b100); m_flag = 3'b100;
        core_ie = 1'b1; core_il = 3'd3;
        waitn(3);
        chk(irq_req == 1'b0, "R6 equal level rejected", irq_req, 0);
        core_il = 3'd2;
        waitn(2);
        chk(irq_req == 1'b1 && irq_vec_num == 8'd15, "R6 level above mask accepted",
            irq_vec_num, 15);
        nmi_pend = 1'b1;
        waitn(2);
        chk(irq_req == 1'b0, "R6 blocked by nmi_pend", irq_req, 0);
        nmi_pend = 1'b0;

        // R8 hold against higher newcomer, then R9 ack
        quiesce();
        m_lvl[0] = 3'd5; m_lvl[1] = 3'd1; m_lvl[2] = 3'd3; put_levels();
        core_ie = 1'b1; core_il = 3'd0;
        pulse(3'b100);
        waitn(2);
        chk(irq_req && irq_vec_num == 8'd15, "R8 channel 2 presented", irq_vec_num, 15);
        pulse(3'b001);
        waitn(2);
        chk(irq_req && irq_vec_num == 8'd15 && irq_level == 3'd3,
            "R8 no preemption by higher level", irq_vec_num, 15);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        chk(irq_req == 1'b0, "R9 request drops after ack", irq_req, 0);
        @(negedge clk);
        chk(irq_req && irq_vec_num == 8'd13 && irq_level == 3'd5,
            "R9 next winner after ack", irq_vec_num, 13);
        rd(3'd0, d);
        chk(d == 16'h0200, "R9 ack clears presented flag only", d, 16'h0200);

        // R4 random rounds
        for (int it = 0; it < 60; it++) begin
            logic [2:0] mask;
            quiesce();
            m_en = 3'($urandom);
            wr(3'd1, {4'd0, m_en, 9'd0});
            for (int c = 0; c < 3; c++) m_lvl[c] = 3'($urandom);
            put_levels();
            mask = 3'($urandom);
            pulse(mask); m_flag = mask;
            core_il  = 3'($urandom);
            core_ie  = ($urandom % 4) != 0;
            nmi_pend = ($urandom % 5) == 0;
            waitn(3);
            expect_out("R4 random");
            rd(3'd0, d);
            chk(d == {4'd0, mask, 9'd0}, "R1 random flag readback", d, {4'd0, mask, 9'd0});
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule